// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is a two-wire serial bus slave that fronts a byte-wide read-only array. It watches the clock and data lines, both oversampled by a fast system clock. It recognises bus start, repeated start and stop conditions, and decodes an 8-bit header made of a 7-bit device address and a direction bit. It answers by pulling the data line low through an open-drain output enable.

A byte pointer survives from one transaction to the next. A read header with no address phase returns data from wherever the pointer stands. A write header followed by two address bytes moves the pointer. The master can then issue a repeated start and a read header, or simply stop. Each byte the slave shifts out advances the pointer. Passing the top of the array wraps it to zero. The master acknowledges every byte it wants more of and refuses the last.

The array depth is set by `ADDR_W`. A full-size build uses 15 bits; the default is kept small. Its contents are a fixed function of the address, so every byte is predictable.

Top module: `i2c_mem_read_slave`

## Requirements
- R1: After reset the output enable `sda_oe` is 0 and the byte pointer is 0, so the first read with no address phase returns the byte at address 0.
- R2: A header whose upper 7 bits equal `DEV_ADDR` (sent MSB first, direction bit last, 1 = read) is acknowledged. The slave holds the data line low for the whole 9th clock pulse.
- R3: A header with any other address gets no acknowledge. `sda_oe` then stays 0 until the next start or stop, and the byte pointer is left unchanged.
- R4: A write header (direction bit 0) followed by two address bytes sets the pointer. Both address bytes are acknowledged. The first byte gives pointer bits 14:8, and its bit 7 plus any bits at or above `ADDR_W` are ignored. The second byte gives bits 7:0. A repeated start and a read header then return data from that address.
- R5: Data bytes go out MSB first. The byte stored at address a is (a mod 256) XOR (a div 256, low 8 bits) XOR 0xA5.
- R6: An acknowledge from the master (data low on the 9th pulse) makes the slave send the byte at the next address. A refusal (data high) makes it release the line and drive nothing more until a start or stop.
- R7: The pointer advances once per byte sent, even for the refused last byte, and it persists across a stop. A read with no address phase therefore starts one past the last byte sent.
- R8: Stepping past address 2^ADDR_W - 1 wraps the pointer to 0. This holds inside a sequential read and between transactions.
- R9: A stop issued right after the two address bytes of a write keeps the newly loaded pointer for the next read.
- R10: `sda_oe` changes only while the synchronised clock line is low. A start or stop at any point releases the line and restarts header reception from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed at the pin |
| sda_i | input | 1 | Bus data line as sensed at the pin |
| sda_oe | output | 1 | Registered open-drain enable; 1 pulls the data line low |

## Verification
Properties checked on every cycle: the output enable moves only while the synchronised clock is low; it is released after a stop; it stays off once the slave has chosen to ignore the bus; a start always restarts header reception; and the pointer changes only by a single step or by an address load. Data values, wrap points, pointer persistence across stops and the acknowledge decisions depend on whole transactions. These only show up in the bench's scenarios: the scoreboard compares every received byte against the address model derived from the requirements.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WDAT,
    ST_IGN
  } st_e;
endpackage

// File: rtl/i2crd_sync.sv
module i2crd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2crd_rom.sv
module i2crd_rom #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] v;
      v = i;
      mem[i] = DATA_W'(v[7:0] ^ v[15:8] ^ 8'hA5);
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2crd_ctrl.sv
module i2crd_ctrl
  import i2crd_pkg::*;
#(
  parameter int         ADDR_W   = 11,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_s,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [BYTE_W-1:0]   rdata,
  output logic [ADDR_W-1:0]   ptr,
  output logic                sda_oe
);
  st_e               state, ack_nxt;
  logic [BIT_CW-1:0] bitcnt;
  logic [BYTE_W-1:0] shreg, hi_q;
  logic              ack_on, got_ack;
  logic [BYTE_W-1:0] rx_byte;
  logic [14:0]       full_addr;

  assign rx_byte   = {shreg[BYTE_W-2:0], sda_s};
  assign full_addr = {hi_q[6:0], rx_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ack_nxt <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      hi_q    <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      ack_on  <= 1'b0;
      got_ack <= 1'b0;
    end else if (start_det) begin
      state   <= ST_DEV;
      bitcnt  <= '0;
      sda_oe  <= 1'b0;
      ack_on  <= 1'b0;
      got_ack <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
      ack_on  <= 1'b0;
      got_ack <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BIT_CW'(BYTE_W - 1)) begin
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (shreg[6:0] == DEV_ADDR) begin
                  state   <= ST_ACK;
                  ack_nxt <= sda_s ? ST_TX : ST_AHI;
                end else begin
                  state <= ST_IGN;
                end
              end else if (state == ST_AHI) begin
                hi_q    <= rx_byte;
                state   <= ST_ACK;
                ack_nxt <= ST_ALO;
              end else begin
                ptr     <= full_addr[ADDR_W-1:0];
                state   <= ST_ACK;
                ack_nxt <= ST_WDAT;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_on) begin
              sda_oe <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              if (ack_nxt == ST_TX) begin
                shreg  <= rdata;
                sda_oe <= ~rdata[BYTE_W-1];
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ack_nxt;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == BIT_CW'(BYTE_W - 1)) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              state  <= ST_MACK;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            got_ack <= ~sda_s;
            if (sda_s) state <= ST_IGN;
          end else if (scl_fall && got_ack) begin
            got_ack <= 1'b0;
            shreg   <= rdata;
            sda_oe  <= ~rdata[BYTE_W-1];
            state   <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: the line is only ever switched while the clock is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R10: a stop always leaves the line released
  a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R10: a start restarts header reception at bit zero
  a_r10_start_restart: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_DEV && bitcnt == '0 && !sda_oe));

  // R3 and R6: once the bus is being ignored the line stays released
  a_r3_ign_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGN) |-> !sda_oe);

  // R7 and R8: the pointer moves by one step (wrapping) or by an address load
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> ((ptr == ADDR_W'($past(ptr) + 1'b1)) || ($past(state) == ST_ALO)));
endmodule

// File: rtl/i2c_mem_read_slave.sv
module i2c_mem_read_slave #(
  parameter int         ADDR_W      = 11,
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2crd_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] rdata;

  i2crd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2crd_rom #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_rom (
    .clk   (clk),
    .raddr (ptr),
    .rdata (rdata)
  );

  i2crd_ctrl #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rdata     (rdata),
    .ptr       (ptr),
    .sda_oe    (sda_oe)
  );
endmodule

// File: tb/i2c_mem_read_slave_tb.sv
`timescale 1ns/100ps
module i2c_mem_read_slave_tb;
  localparam int         AW  = 11;
  localparam logic [6:0] DEV = 7'h50;
  localparam int         Q   = 5;
  localparam int         TOP = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_read_slave #(.ADDR_W(AW), .DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int n_vec = 0, n_bad = 0, model_ptr = 0, drive_cnt = 0, high_moves = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_byte;
  event       got_ev;
  logic       oe_prev = 1'b0;

  function automatic logic [7:0] content(int a);
    int m;
    m = a & TOP;
    return 8'(m & 255) ^ 8'((m >> 8) & 255) ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pin activity and scoreboard
  always @(negedge clk) begin
    if (sda_oe) drive_cnt++;
    if (sda_oe !== oe_prev && scl_m) high_moves++;
    oe_prev = sda_oe;
  end

  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) chk(0, "scoreboard-empty", got_byte, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got_byte == e, t, got_byte, e);
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(bit mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic hdr(logic [6:0] a, logic rw, bit exp_ack, string req);
    logic ak;
    send_byte({a, rw}, ak);
    chk(ak == exp_ack, req, ak, exp_ack);
  endtask

  // driver: pushes expected bytes, then clocks them out of the slave
  task automatic rd(int n, string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      exp_q.push_back(content(model_ptr));
      tag_q.push_back(req);
      recv_byte(i < n - 1, v);
      got_byte = v;
      -> got_ev;
      model_ptr = (model_ptr + 1) & TOP;
    end
  endtask

  task automatic set_addr(logic [7:0] hi, logic [7:0] lo, string req);
    logic ak;
    bstart();
    hdr(DEV, 1'b0, 1, req);
    send_byte(hi, ak); chk(ak, {req, " hi-ack"}, ak, 1);
    send_byte(lo, ak); chk(ak, {req, " lo-ack"}, ak, 1);
    model_ptr = ((int'(hi & 8'h7F) << 8) | int'(lo)) & TOP;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);

    // R1 R2 R5 R7: read with no address phase from reset
    bstart(); hdr(DEV, 1'b1, 1, "R2 read header ack");
    rd(1, "R1 first byte at 0"); bstop();

    // R4 R5 R6: random read, bit 7 of hi byte and high bits ignored
    set_addr(8'h81, 8'h23, "R4 dummy write");
    bstart(); hdr(DEV, 1'b1, 1, "R4 read after repeated start");
    rd(3, "R4 R6 sequential from loaded address"); bstop();

    // R7: pointer persists across stop
    bstart(); hdr(DEV, 1'b1, 1, "R7 header");
    rd(1, "R7 resume one past last"); bstop();

    // R9 R8: stop after address, then a wrapping sequential read
    set_addr(8'h07, 8'hFE, "R9 dummy write");
    bstop();
    bstart(); hdr(DEV, 1'b1, 1, "R9 header");
    rd(4, "R9 R8 wrap within sequence"); bstop();

    // R8: wrap between transactions
    set_addr(8'h07, 8'hFF, "R8 dummy write");
    bstart(); hdr(DEV, 1'b1, 1, "R8 header");
    rd(1, "R8 top byte"); bstop();
    bstart(); hdr(DEV, 1'b1, 1, "R8 header 2");
    rd(1, "R8 wrapped to zero"); bstop();

    // R3: foreign address is ignored and pointer untouched
    snap = drive_cnt;
    bstart(); hdr(7'h51, 1'b1, 0, "R3 no ack");
    for (int i = 0; i < 9; i++) begin
      logic b;
      recv_bit(b);
    end
    bstop();
    chk(drive_cnt == snap, "R3 line never driven", drive_cnt - snap, 0);
    bstart(); hdr(DEV, 1'b1, 1, "R3 header after");
    rd(1, "R3 pointer unchanged"); bstop();

    // R6: after refusal the slave stays off the line
    bstart(); hdr(DEV, 1'b1, 1, "R6 header");
    rd(1, "R6 last byte");
    snap = drive_cnt;
    for (int i = 0; i < 9; i++) begin
      logic b;
      recv_bit(b);
    end
    chk(drive_cnt == snap, "R6 released after refusal", drive_cnt - snap, 0);
    bstop();

    // R10: start in mid-header restarts reception
    bstart();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bstart(); hdr(DEV, 1'b1, 1, "R10 header after restart");
    rd(2, "R10 data after restart"); bstop();
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    chk(high_moves == 0, "R10 oe moved with clock high", high_moves, 0);

    repeat (10) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule